// File: doc/BRIEF.md
# DDR3 Power-Up and Mode-Register Initialization Sequencer

This block takes a DDR3 memory from reset to a configured, calibrated state without software help. A single start pulse captures three timing values: write recovery, CAS latency and CAS write latency. The block then raises a power-up request towards the memory controller and waits for the controller to report that power-up is complete. If that report does not arrive within a bounded number of cycles, the block flags an error and returns to idle.

Once power-up completes, the block drives a fixed series of controller commands through a command-register-style port. For each command it pulses a write strobe together with a 32-bit command word. The controller holds a busy flag, which is the start bit of its command register, until the command has finished. The block issues nothing further until that flag reads clear. The series is: deselect, a wait of about one microsecond, precharge-all, four mode-register writes in the order MR2, MR3, MR1, MR0, and a long ZQ calibration. Every command goes to both ranks. The block packs the mode-register contents itself from the captured timing values.

A single-cycle done pulse marks the end of the ZQ calibration. The wait length and the power-up timeout are set by parameters, from the clock frequency and a cycle limit.

Top module: `ddr3_init_seq`

## Requirements
- R1: After reset, busy, done, err, pwr_req and cmd_wr are all low.
- R2: A start pulse while idle raises pwr_req and busy on the next cycle. pwr_req stays high until pwr_done is seen or the timeout expires.
- R3: If pwr_done is not seen for TIMEOUT_CYCLES cycles while pwr_req is high, err pulses for one cycle in the cycle pwr_req falls. No command is issued and the block returns to idle. done and err are never high together.
- R4: After power-up the commands are issued in this order: DESELECT (opcode 0), PREA (1), MRS to MR2, MRS to MR3, MRS to MR1, MRS to MR0 (opcode 3), then ZQCL (5). Exactly seven commands are issued per run.
- R5: In each command word, bit 31 is 1 and bits 21:20 are both 1 (rank 1 and rank 0). Bits 19:17 hold the mode-register number, bits 16:4 hold the mode-register data, and bits 3:0 hold the opcode. The unused fields are zero.
- R6: cmd_wr is a one-cycle pulse. The controller's cmd_pending flag goes high in the cycle that follows the pulse. No new pulse occurs until cmd_pending has been observed low after the previous command.
- R7: After DESELECT completes, at least GAP_CYCLES = ceil(CLK_MHZ*WAIT_NS/1000) cycles pass before PREA is written. At the defaults (200 MHz, 1000 ns) this is 200 cycles.
- R8: MR0 data is built as follows. Bits 11:9 hold tWR-4 when tWR is at most 8, and (tWR>>1)&7 otherwise. Bit 8 is 1 (DLL reset). Bits 6:4 hold (CL-4)&7. Bit 2 holds bit 3 of (CL-4). All other bits are 0, which selects burst length 8.
- R9: MR1 data is 0x040. MR2 data is ((CWL-5)&7) in bits 5:3. MR3 data is 0.
- R10: done pulses for exactly one cycle, after cmd_pending clears following ZQCL. busy then falls with it.
- R11: twr, cl and cwl are captured at start. Changes to them during a run do not affect the words issued.
- R12: A start pulse while busy is ignored. It neither restarts the run nor adds commands or done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an initialization run (pulse) |
| twr | input | T_W | Write recovery in clocks |
| cl | input | T_W | CAS latency in clocks |
| cwl | input | T_W | CAS write latency in clocks |
| pwr_done | input | 1 | Controller reports power-up complete |
| cmd_pending | input | 1 | Start flag readback of the command register |
| pwr_req | output | 1 | Power-up request |
| cmd_wr | output | 1 | Command register write strobe |
| cmd_word | output | 32 | Command word written with cmd_wr |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed (one cycle) |
| err | output | 1 | Power-up timeout (one cycle) |

## Verification
The bench checks the edge encodings of the mode-register fields. With tWR of 16 the write-recovery field wraps to 0, and with CL of 12 only bit 2 is set, leaving the CAS field empty. A design that took the wrong tWR branch, or dropped the high CAS-latency bit, would produce an MR0 word that mismatches the scoreboard. The bench also varies how long the controller keeps its busy flag high. A design that issued on a stale flag, or shortened the post-deselect wait, would be caught by the stall and gap checks. A power-up that never completes must produce exactly one err pulse after the configured limit and no commands. A design that kept waiting, or went on to issue commands, would show as a missing err or as unexpected scoreboard entries. Start pulses landing during power-up and during the wait, together with timing inputs changed mid-run, expose any design that restarts or samples its inputs late.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        OP_DESEL = 4'd0,
        OP_PREA  = 4'd1,
        OP_REF   = 4'd2,
        OP_MRS   = 4'd3,
        OP_ZQCS  = 4'd4,
        OP_ZQCL  = 4'd5,
        OP_RSTL  = 4'd6,
        OP_MRR   = 4'd8,
        OP_DPDE  = 4'd9
    } cmd_op_e;

    localparam int WORD_W     = 32;
    localparam int START_BIT  = 31;
    localparam int RANK_LSB   = 20;
    localparam int MRNUM_LSB  = 17;
    localparam int MRNUM_W    = 3;
    localparam int MRDATA_LSB = 4;
    localparam int MR_W       = 13;
    localparam int NUM_STEPS  = 7;
    localparam int STEP_W     = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PWR,
        ST_CMD,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        cmd_op_e    op;
        logic [1:0] mr;
    } step_t;

    // Issue order of the power-up series; index 0 is followed by the settle wait.
    function automatic step_t step_info(logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            3'd0:    s = '{op: OP_DESEL, mr: 2'd0};
            3'd1:    s = '{op: OP_PREA,  mr: 2'd0};
            3'd2:    s = '{op: OP_MRS,   mr: 2'd2};
            3'd3:    s = '{op: OP_MRS,   mr: 2'd3};
            3'd4:    s = '{op: OP_MRS,   mr: 2'd1};
            3'd5:    s = '{op: OP_MRS,   mr: 2'd0};
            default: s = '{op: OP_ZQCL,  mr: 2'd0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr3_mr_encode.sv
module ddr3_mr_encode
    import ddr3_init_pkg::*;
#(
    parameter int T_W = 5
) (
    input  logic [T_W-1:0]  twr,
    input  logic [T_W-1:0]  cl,
    input  logic [T_W-1:0]  cwl,
    output logic [MR_W-1:0] mr0,
    output logic [MR_W-1:0] mr1,
    output logic [MR_W-1:0] mr2,
    output logic [MR_W-1:0] mr3
);

    logic [2:0] wr_fld;
    logic [3:0] cl_m4;
    logic [2:0] cwl_m5;

    always_comb begin
        if (twr <= T_W'(8)) begin
            wr_fld = 3'(twr - T_W'(4));
        end else begin
            wr_fld = 3'(twr >> 1);
        end
        cl_m4  = 4'(cl - T_W'(4));
        cwl_m5 = 3'(cwl - T_W'(5));
    end

    // R8: write recovery, DLL reset, split CAS latency, BL8 = 0
    assign mr0 = {1'b0, wr_fld, 1'b1, 1'b0, cl_m4[2:0], 1'b0, cl_m4[3], 2'b00};
    // R9: 120 ohm termination only
    assign mr1 = MR_W'(13'h040);
    assign mr2 = {7'b0, cwl_m5, 3'b000};
    assign mr3 = '0;

endmodule

// File: rtl/ddr3_cmd_pack.sv
module ddr3_cmd_pack
    import ddr3_init_pkg::*;
#(
    parameter int NUM_RANKS = 2
) (
    input  logic [STEP_W-1:0] step,
    input  logic [MR_W-1:0]   mr0,
    input  logic [MR_W-1:0]   mr1,
    input  logic [MR_W-1:0]   mr2,
    input  logic [MR_W-1:0]   mr3,
    output logic [WORD_W-1:0] word
);

    step_t            s;
    logic [MR_W-1:0]  data;
    logic [NUM_RANKS-1:0] rank_mask;

    // R5: every rank select bit is raised
    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
        assign rank_mask[g] = 1'b1;
    end

    always_comb begin
        s = step_info(step);
        if (s.op == OP_MRS) begin
            case (s.mr)
                2'd0:    data = mr0;
                2'd1:    data = mr1;
                2'd2:    data = mr2;
                default: data = mr3;
            endcase
        end else begin
            data = '0;
        end
        word                             = '0;
        word[START_BIT]                  = 1'b1;
        word[RANK_LSB +: NUM_RANKS]      = rank_mask;
        word[MRNUM_LSB +: MRNUM_W]       = MRNUM_W'(s.mr);
        word[MRDATA_LSB +: MR_W]         = data;
        word[3:0]                        = s.op;
    end

endmodule

// File: rtl/ddr3_wait_timer.sv
module ddr3_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R7: an unloaded counter that reached zero stays there
    p_timer_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

    // R7: a loaded nonzero count steps down by one
    p_timer_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int T_W            = 5,
    parameter int CLK_MHZ        = 200,
    parameter int WAIT_NS        = 1000,
    parameter int TIMEOUT_CYCLES = 100000,
    parameter int NUM_RANKS      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [T_W-1:0]    twr,
    input  logic [T_W-1:0]    cl,
    input  logic [T_W-1:0]    cwl,
    input  logic              pwr_done,
    input  logic              cmd_pending,
    output logic              pwr_req,
    output logic              cmd_wr,
    output logic [WORD_W-1:0] cmd_word,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int GAP_CYCLES = (CLK_MHZ * WAIT_NS + 999) / 1000;
    localparam int CNT_MAX    = (GAP_CYCLES > TIMEOUT_CYCLES) ? GAP_CYCLES : TIMEOUT_CYCLES;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  TO_LOAD  = CNT_W'(TIMEOUT_CYCLES - 1);
    localparam logic [CNT_W-1:0]  GAP_LOAD = CNT_W'(GAP_CYCLES - 1);
    localparam logic [STEP_W-1:0] LAST     = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        seq_state_e          st;
        logic [STEP_W-1:0]   step;
        logic [T_W-1:0]      twr;
        logic [T_W-1:0]      cl;
        logic [T_W-1:0]      cwl;
        logic                pwr_req;
        logic                cmd_wr;
        logic [WORD_W-1:0]   word;
        logic                done;
        logic                err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [STEP_W-1:0] issue_step;
    logic [WORD_W-1:0] issue_word;
    logic [MR_W-1:0]   mr0, mr1, mr2, mr3;

    ddr3_mr_encode #(.T_W(T_W)) u_enc (
        .twr (r_q.twr),
        .cl  (r_q.cl),
        .cwl (r_q.cwl),
        .mr0 (mr0),
        .mr1 (mr1),
        .mr2 (mr2),
        .mr3 (mr3)
    );

    assign issue_step = (r_q.st == ST_PWR) ? '0 : r_q.step + 1'b1;

    ddr3_cmd_pack #(.NUM_RANKS(NUM_RANKS)) u_pack (
        .step (issue_step),
        .mr0  (mr0),
        .mr1  (mr1),
        .mr2  (mr2),
        .mr3  (mr3),
        .word (issue_word)
    );

    ddr3_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        r_d        = r_q;
        r_d.cmd_wr = 1'b0;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st      = ST_PWR;
                    r_d.pwr_req = 1'b1;
                    r_d.twr     = twr;
                    r_d.cl      = cl;
                    r_d.cwl     = cwl;
                    tmr_load    = 1'b1;
                    tmr_val     = TO_LOAD;
                end
            end
            ST_PWR: begin
                if (pwr_done) begin
                    r_d.pwr_req = 1'b0;
                    r_d.st      = ST_CMD;
                    r_d.step    = issue_step;
                    r_d.cmd_wr  = 1'b1;
                    r_d.word    = issue_word;
                end else if (tmr_exp) begin
                    r_d.pwr_req = 1'b0;
                    r_d.err     = 1'b1;
                    r_d.st      = ST_IDLE;
                end
            end
            ST_CMD: begin
                // the flag is only meaningful once the strobe cycle is over
                if (!r_q.cmd_wr && !cmd_pending) begin
                    if (r_q.step == LAST) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.step == '0) begin
                        r_d.st   = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = GAP_LOAD;
                    end else begin
                        r_d.step   = issue_step;
                        r_d.cmd_wr = 1'b1;
                        r_d.word   = issue_word;
                    end
                end
            end
            default: begin
                if (tmr_exp) begin
                    r_d.st     = ST_CMD;
                    r_d.step   = issue_step;
                    r_d.cmd_wr = 1'b1;
                    r_d.word   = issue_word;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_req  = r_q.pwr_req;
    assign cmd_wr   = r_q.cmd_wr;
    assign cmd_word = r_q.word;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign err      = r_q.err;

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_wr);

    p_wait_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_wr) |-> !$past(cmd_pending));

    p_both_ranks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> (cmd_word[START_BIT] && cmd_word[RANK_LSB +: NUM_RANKS] == '1));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_pwr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req && !pwr_done && !tmr_exp) |=> pwr_req);

    p_no_cmd_on_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!cmd_wr && !busy));

endmodule

// File: tb/ddr3_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr3_init_seq_tb_top;

    localparam int T_W  = 5;
    localparam int TO   = 300;
    localparam int GAP  = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  twr = '0, cl = '0, cwl = '0;
    logic        pwr_done = 1'b0;
    logic        cmd_pending = 1'b0;
    logic        pwr_req, cmd_wr, busy, done, err;
    logic [31:0] cmd_word;

    always #2.5 clk = ~clk;

    ddr3_init_seq #(
        .T_W(T_W), .CLK_MHZ(200), .WAIT_NS(1000),
        .TIMEOUT_CYCLES(TO), .NUM_RANKS(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .twr(twr), .cl(cl), .cwl(cwl),
        .pwr_done(pwr_done), .cmd_pending(cmd_pending),
        .pwr_req(pwr_req), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .busy(busy), .done(done), .err(err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];

    int cyc = 0, clr_cyc = 0, pend_left = 0, run_idx = 0, total_cmds = 0;
    int done_cnt = 0, err_cnt = 0, pr_len = 0, last_len = 0;
    bit pr_prev = 0, err_at_fall = 0, done_prev = 0, pwr_ok = 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int mr, input int data);
        return (32'd1 << 31) | (32'd3 << 20) | (32'(mr) << 17) | (32'(data) << 4) | 32'(op);
    endfunction

    function automatic int exp_mr0(input int t, input int c);
        int w, d;
        w = (t <= 8) ? (t - 4) : ((t / 2) % 8);
        d = c - 4;
        return w * 512 + 256 + (d % 8) * 16 + ((d / 8) % 2) * 4;
    endfunction

    // monitor: controller register model and scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (cmd_wr) begin
                    check(cmd_pending == 1'b0, "R6 write while pending", cmd_pending, 0);
                    if (exp_q.size() == 0) begin
                        check(0, "R4 unexpected command", cmd_word, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(cmd_word == e, "R4/R5/R8/R9 command word", cmd_word, e);
                    end
                    if (run_idx == 1) begin
                        check((cyc - clr_cyc) >= GAP && (cyc - clr_cyc) <= GAP + 2,
                              "R7 settle gap", cyc - clr_cyc, GAP + 1);
                    end
                    run_idx++;
                    total_cmds++;
                    cmd_pending = 1'b1;
                    pend_left   = 2 + (cyc % 4);
                end else if (pend_left > 0) begin
                    pend_left--;
                    if (pend_left == 0) begin
                        cmd_pending = 1'b0;
                        clr_cyc     = cyc;
                    end
                end
                if (done) begin
                    done_cnt++;
                    check(!done_prev, "R10 done width", 2, 1);
                    check(exp_q.size() == 0 && cmd_pending == 1'b0, "R10 done early",
                          exp_q.size(), 0);
                end
                done_prev = done;
                if (err) err_cnt++;
                if (pwr_req) begin
                    pr_len++;
                end else if (pr_prev) begin
                    last_len    = pr_len;
                    err_at_fall = err;
                    pr_len      = 0;
                end
                pr_prev = pwr_req;
            end
        end
    end

    // power-up responder
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (pwr_req && pwr_ok) begin
                cnt++;
                if (cnt >= 4) pwr_done = 1'b1;
            end else begin
                pwr_done = 1'b0;
                cnt = 0;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    task automatic run_ok(input int t, input int c, input int w);
        int d0, c0;
        d0 = done_cnt;
        c0 = total_cmds;
        exp_q.push_back(mk(0, 0, 0));
        exp_q.push_back(mk(1, 0, 0));
        exp_q.push_back(mk(3, 2, ((w - 5) % 8) * 8));
        exp_q.push_back(mk(3, 3, 0));
        exp_q.push_back(mk(3, 1, 'h40));
        exp_q.push_back(mk(3, 0, exp_mr0(t, c)));
        exp_q.push_back(mk(5, 0, 0));
        run_idx = 0;
        @(negedge clk);
        twr = 5'(t); cl = 5'(c); cwl = 5'(w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(pwr_req && busy, "R2 request after start", {pwr_req, busy}, 3);
        // R11: scramble timing inputs after capture
        twr = 5'd31; cl = 5'd31; cwl = 5'd31;
        // R12: start while waiting for power-up
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        // R12: start during the settle wait
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(done_cnt == d0 + 1, "R10/R12 single done", done_cnt - d0, 1);
        check(total_cmds - c0 == 7, "R4 command count", total_cmds - c0, 7);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        check(!busy, "R10 idle after done", busy, 0);
        repeat (20) @(negedge clk);
        check(total_cmds - c0 == 7 && !busy, "R12 no restart", total_cmds - c0, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !pwr_req && !cmd_wr, "R1 reset state",
              {busy, done, err, pwr_req, cmd_wr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !pwr_req, "R1 idle after release", {busy, pwr_req}, 0);

        run_ok(12, 11, 8);   // R8 tWR > 8 branch
        run_ok(6, 6, 5);     // R8 tWR <= 8 branch, R9 CWL floor
        run_ok(16, 12, 10);  // R8 tWR wrap to 0, CL high bit at bit 2
        run_ok(5, 5, 7);

        // R3: power-up never completes
        begin
            int e0, c0;
            e0 = err_cnt;
            c0 = total_cmds;
            pwr_ok = 0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (err_cnt == e0) @(negedge clk);
            repeat (3) @(negedge clk);
            check(last_len == TO, "R3 timeout length", last_len, TO);
            check(err_at_fall, "R3 err with request drop", err_at_fall, 1);
            check(err_cnt == e0 + 1, "R3 single err", err_cnt - e0, 1);
            check(total_cmds == c0 && !busy, "R3 no commands", total_cmds - c0, 0);
            pwr_ok = 1;
        end

        run_ok(8, 9, 6);     // R2 recovery after timeout
        finish_run();
    end

endmodule